// File: doc/BRIEF.md
# Host Port Status and Control Register

This block holds the per-port status and control word of a USB host controller. Each downstream port has one 32-bit word on a simple register bus. Ports sit at a fixed base offset, with a fixed stride between them. Writes land on the rising clock edge. Reads are combinational from the address.

The word carries the following fields:
- three wake-event enables;
- a four-bit port test mode;
- a port-ownership bit, which hands the port to a companion controller;
- a port-power bit;
- a two-bit view of the sampled D+/D- line levels.

A global configure flag forces ownership. Its rising edge claims every port for this controller, and while the flag is low every port belongs to the companion. A capability strap tells whether port power switching exists. Without switching, power reads as always on. With switching, an overcurrent on a powered port cuts power. Line status is shown only when it means something. Otherwise it reads as zero.

Top module: `hc_port_ctrl`

## Requirements
- R1: Port i (0-based) is at byte address 0x64 + 4*i. Any other address reads 0x00000000, and a write to it changes no port.
- R2: Bits 22, 21 and 20 are read/write and reset to 0. They are the overcurrent, disconnect and connect wake enables.
- R3: Bits 19:16 store any written test-mode code and read back as written. Valid codes are 0 (off), 1 (J), 2 (K), 3 (SE0/NAK), 4 (packet) and 5 (force enable). The `testModeEff` output carries the stored code when it is 0..5 and 0 for codes 6..15. The nibble for port i sits at bits 4i+3:4i.
- R4: The owner bit (bit 13, also `portOwner[i]`) resets to 1. While `cfgFlag` is 0 it is 1 in the cycle after, whatever is written.
- R5: A 0-to-1 change of `cfgFlag` clears the owner bit of every port at the next edge. This wins over a software write in the same cycle. Otherwise a write to bit 13 sets the owner.
- R6: With `pwrCtlCap` = 0, the power bit (bit 12, also `portPower[i]`) reads 1 and writes to it have no effect.
- R7: With `pwrCtlCap` = 1, the power bit is read/write and resets to 0. An `overCurrent[i]` sampled while the port is powered clears the bit at that edge. This wins over a write of 1 in the same cycle.
- R8: Bit 11 shows D+ and bit 10 shows D- (00 SE0, 01 K, 10 J). These bits are shown only when the port is powered, `connStat` is 1 and `portEn` is 0. Otherwise the field reads 00.
- R9: Bits 31:23, 15:14 and 9:0 read 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| cfgFlag | input | 1 | Global configure flag |
| pwrCtlCap | input | 1 | Port power switching present |
| overCurrent | input | NPORTS | Overcurrent per port |
| connStat | input | NPORTS | Device connected per port |
| portEn | input | NPORTS | Port enabled per port |
| lineDp | input | NPORTS | Sampled D+ per port |
| lineDm | input | NPORTS | Sampled D- per port |
| portOwner | output | NPORTS | Owner bit per port (1 = companion) |
| portPower | output | NPORTS | Effective power per port |
| testModeEff | output | 4*NPORTS | Effective test mode per port |

## Verification
Two pairs of functions can act on one bit at the same edge.
- **Ownership.** The bench raises `cfgFlag` on the same edge as a write of 1 to the owner bit. It judges that the owner reads 0 afterwards.
- **Power.** The bench asserts `overCurrent` on the same edge as a write of 1 to the power bit. It judges that power reads 0.

Both collisions are also watched by clocked properties on the ports.

// File: rtl/hc_port_pkg.sv
package hc_port_pkg;
  localparam int REG_W = 32;

  typedef enum logic [3:0] {
    TM_OFF     = 4'd0,
    TM_J       = 4'd1,
    TM_K       = 4'd2,
    TM_SE0NAK  = 4'd3,
    TM_PACKET  = 4'd4,
    TM_FORCEEN = 4'd5
  } testMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgRise;
    logic cfgLow;
    logic wrStrobe;
  } ctrlStrobe_t;

  localparam int BIT_WAKE_HI = 22;
  localparam int BIT_WAKE_LO = 20;
  localparam int BIT_TM_HI   = 19;
  localparam int BIT_TM_LO   = 16;
  localparam int BIT_OWNER   = 13;
  localparam int BIT_POWER   = 12;
  localparam logic [REG_W-1:0] RSVD_MASK = 32'hFF80_C3FF;
endpackage

// File: rtl/hc_port_ctrl_seq.sv
module hc_port_ctrl_seq
  import hc_port_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h64,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              cfgFlag,
  output ctrlStrobe_t       strobe,
  output logic [NPORTS-1:0] portHit
);
  logic cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= 1'b0;
    else       cfgQ <= cfgFlag;
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_dec
    localparam int PORT_ADDR = BASE + STRIDE * i;
    assign portHit[i] = (busAddr == ADDR_W'(PORT_ADDR));
  end

  always_comb begin
    strobe.cfgRise  = cfgFlag & ~cfgQ;
    strobe.cfgLow   = ~cfgFlag;
    strobe.wrStrobe = busWrEn;
  end
endmodule

// File: rtl/hc_port_regs.sv
module hc_port_regs
  import hc_port_pkg::*;
#(
  parameter int NPORTS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [NPORTS-1:0]   portHit,
  input  logic [REG_W-1:0]    busWdata,
  input  logic                pwrCtlCap,
  input  logic [NPORTS-1:0]   overCurrent,
  input  logic [NPORTS-1:0]   connStat,
  input  logic [NPORTS-1:0]   portEn,
  input  logic [NPORTS-1:0]   lineDp,
  input  logic [NPORTS-1:0]   lineDm,
  output logic [REG_W-1:0]    busRdata,
  output logic [NPORTS-1:0]   portOwner,
  output logic [NPORTS-1:0]   portPower,
  output logic [4*NPORTS-1:0] testModeEff
);
  localparam int TM_W = BIT_TM_HI - BIT_TM_LO + 1;
  localparam int WK_W = BIT_WAKE_HI - BIT_WAKE_LO + 1;

  logic [REG_W-1:0] portWord [NPORTS];

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic [WK_W-1:0] wakeQ;
    logic [TM_W-1:0] tmQ;
    logic            ownQ;
    logic            pwrQ;
    logic            wrHere;
    logic            pwrEff;
    logic            lsValid;
    logic [1:0]      lineStat;

    assign wrHere = strobe.wrStrobe & portHit[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wakeQ <= '0;
        tmQ   <= TM_OFF;
        ownQ  <= 1'b1;
        pwrQ  <= 1'b0;
      end else begin
        if (wrHere) begin
          wakeQ <= busWdata[BIT_WAKE_HI:BIT_WAKE_LO];
          tmQ   <= busWdata[BIT_TM_HI:BIT_TM_LO];
        end
        if (strobe.cfgLow)       ownQ <= 1'b1;
        else if (strobe.cfgRise) ownQ <= 1'b0;
        else if (wrHere)         ownQ <= busWdata[BIT_OWNER];
        if (pwrCtlCap && pwrQ && overCurrent[i]) pwrQ <= 1'b0;
        else if (wrHere && pwrCtlCap)            pwrQ <= busWdata[BIT_POWER];
      end
    end

    assign pwrEff   = pwrCtlCap ? pwrQ : 1'b1;
    assign lsValid  = pwrEff & connStat[i] & ~portEn[i];
    assign lineStat = lsValid ? {lineDp[i], lineDm[i]} : 2'b00;

    assign portWord[i] = {9'b0, wakeQ, tmQ, 2'b00, ownQ, pwrEff, lineStat, 10'b0};
    assign portOwner[i] = ownQ;
    assign portPower[i] = pwrEff;
    assign testModeEff[4*i +: 4] = (tmQ <= TM_FORCEEN) ? tmQ : TM_OFF;
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (portHit[i]) busRdata = portWord[i];
    end
  end
endmodule

// File: rtl/hc_port_ctrl.sv
module hc_port_ctrl
  import hc_port_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h64,
  parameter int STRIDE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic                cfgFlag,
  input  logic                pwrCtlCap,
  input  logic [NPORTS-1:0]   overCurrent,
  input  logic [NPORTS-1:0]   connStat,
  input  logic [NPORTS-1:0]   portEn,
  input  logic [NPORTS-1:0]   lineDp,
  input  logic [NPORTS-1:0]   lineDm,
  output logic [NPORTS-1:0]   portOwner,
  output logic [NPORTS-1:0]   portPower,
  output logic [4*NPORTS-1:0] testModeEff
);
  ctrlStrobe_t       strobe;
  logic [NPORTS-1:0] portHit;

  hc_port_ctrl_seq #(
    .NPORTS(NPORTS), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) u_seq (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .cfgFlag(cfgFlag), .strobe(strobe), .portHit(portHit)
  );

  hc_port_regs #(.NPORTS(NPORTS)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .portHit(portHit),
    .busWdata(busWdata), .pwrCtlCap(pwrCtlCap), .overCurrent(overCurrent),
    .connStat(connStat), .portEn(portEn), .lineDp(lineDp), .lineDm(lineDm),
    .busRdata(busRdata), .portOwner(portOwner), .portPower(portPower),
    .testModeEff(testModeEff)
  );
endmodule

// File: rtl/hc_port_chk.sv
module hc_port_chk
  import hc_port_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h64,
  parameter int STRIDE = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [31:0]         busWdata,
  input logic [31:0]         busRdata,
  input logic                cfgFlag,
  input logic                pwrCtlCap,
  input logic [NPORTS-1:0]   overCurrent,
  input logic [NPORTS-1:0]   portEn,
  input logic [NPORTS-1:0]   portOwner,
  input logic [NPORTS-1:0]   portPower
);
  localparam int LAST = BASE + STRIDE * (NPORTS - 1);
  logic inWindow;
  assign inWindow = (int'(busAddr) >= BASE) && (int'(busAddr) <= LAST) &&
                    ((int'(busAddr) - BASE) % STRIDE == 0);

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inWindow |-> busRdata == 32'h0);

  p_owner_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgFlag |=> &portOwner);

  p_owner_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgFlag) |=> portOwner == '0);

  p_power_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pwrCtlCap |-> &portPower);

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & RSVD_MASK) == 32'h0);

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    p_oc_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
      (pwrCtlCap && portPower[i] && overCurrent[i]) ##1 pwrCtlCap |-> !portPower[i]);
    p_ls_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr == ADDR_W'(BASE + STRIDE * i) && portEn[i]) |-> busRdata[11:10] == 2'b00);
  end
endmodule

bind hc_port_ctrl hc_port_chk #(
  .NPORTS(NPORTS), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWdata(busWdata), .busRdata(busRdata), .cfgFlag(cfgFlag),
  .pwrCtlCap(pwrCtlCap), .overCurrent(overCurrent), .portEn(portEn),
  .portOwner(portOwner), .portPower(portPower)
);

// File: tb/sim_hc_port_ctrl.sv
module sim_hc_port_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        cfgFlag, pwrCtlCap;
  logic [1:0]  overCurrent, connStat, portEn, lineDp, lineDm;
  logic [1:0]  portOwner, portPower;
  logic [7:0]  testModeEff;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  hc_port_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .cfgFlag(cfgFlag),
    .pwrCtlCap(pwrCtlCap), .overCurrent(overCurrent), .connStat(connStat),
    .portEn(portEn), .lineDp(lineDp), .lineDm(lineDm),
    .portOwner(portOwner), .portPower(portPower), .testModeEff(testModeEff)
  );

  typedef struct packed {
    logic        portSel;
    logic [31:0] wdata;
    logic        dp;
    logic        dm;
    logic [31:0] expRd;
  } vec_t;

  // cfgFlag=1, cap=1, connected, disabled port
  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h0070_3000, 1'b1, 1'b0, 32'h0070_3800},
    '{1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h007F_3400},
    '{1'b0, 32'h0005_0000, 1'b1, 1'b1, 32'h0005_0000},
    '{1'b1, 32'h0010_1000, 1'b0, 1'b0, 32'h0010_1000},
    '{1'b0, 32'h0003_2000, 1'b1, 1'b0, 32'h0003_2000},
    '{1'b1, 32'h0004_1000, 1'b1, 1'b1, 32'h0004_1C00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] r, keep;
    rstN = 1'b0; busAddr = 8'h00; busWrEn = 1'b0; busWdata = '0;
    cfgFlag = 1'b0; pwrCtlCap = 1'b1; overCurrent = '0;
    connStat = 2'b11; portEn = '0; lineDp = '0; lineDm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // reset state: R2 wake 0, R4 owner 1, R7 power 0
    rd(8'h64, r); check("R2/R4/R7 reset word", r, 32'h0000_2000);
    check("R4 reset owner", {30'b0, portOwner}, 32'h3);

    // R6 no switching: power reads 1, write ignored
    pwrCtlCap = 1'b0;
    rd(8'h64, r); check("R6 power fixed on", r, 32'h0000_3000);
    wr(8'h64, 32'h0000_0000);
    check("R6 portPower", {30'b0, portPower}, 32'h3);
    pwrCtlCap = 1'b1;
    // R4 owner write ignored while flag low; R6 stored power untouched
    rd(8'h64, r); check("R4/R6 after write", r, 32'h0000_2000);

    // R5 rising flag vs same-cycle owner write
    @(negedge clk);
    cfgFlag = 1'b1; busAddr = 8'h64; busWdata = 32'h0000_2000; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk) busWrEn = 1'b0;
    check("R5 rise beats write", {30'b0, portOwner}, 32'h0);

    // table of vectors: R1 addressing, R2, R3, R5 write, R7, R8, R9
    for (int k = 0; k < 6; k++) begin
      lineDp = {2{VECS[k].dp}};
      lineDm = {2{VECS[k].dm}};
      wr(VECS[k].portSel ? 8'h68 : 8'h64, VECS[k].wdata);
      rd(VECS[k].portSel ? 8'h68 : 8'h64, r);
      check($sformatf("R1/R2/R3/R5/R7/R8/R9 vector %0d", k), r, VECS[k].expRd);
    end

    // R3 effective codes: port0=3, port1=4; reserved code 7 -> 0
    check("R3 eff codes", {24'b0, testModeEff}, 32'h43);
    wr(8'h64, 32'h0007_0000);
    rd(8'h64, r); check("R3 stored reserved", r & 32'h000F_0000, 32'h0007_0000);
    check("R3 reserved eff", {28'b0, testModeEff[3:0]}, 32'h0);

    // R7 overcurrent clears only affected port
    wr(8'h64, 32'h0000_1000);
    wr(8'h68, 32'h0000_1000);
    @(negedge clk) overCurrent = 2'b01;
    @(negedge clk) overCurrent = 2'b00;
    check("R7 oc drop", {30'b0, portPower}, 32'h2);
    // R7 overcurrent beats same-cycle write of 1
    wr(8'h64, 32'h0000_1000);
    @(negedge clk);
    overCurrent = 2'b01; busAddr = 8'h64; busWdata = 32'h0000_1000; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk) begin busWrEn = 1'b0; overCurrent = 2'b00; end
    check("R7 oc beats write", {31'b0, portPower[0]}, 32'h0);

    // R8 gating on port1 (powered), D+=1 D-=0
    lineDp = 2'b11; lineDm = 2'b00;
    portEn = 2'b10;
    rd(8'h68, r); check("R8 enabled -> 00", (r >> 10) & 32'h3, 32'h0);
    portEn = 2'b00; connStat = 2'b00;
    rd(8'h68, r); check("R8 no device -> 00", (r >> 10) & 32'h3, 32'h0);
    connStat = 2'b11;
    rd(8'h68, r); check("R8 valid J", (r >> 10) & 32'h3, 32'h2);

    // R1 unmapped read and write
    rd(8'h64, keep);
    rd(8'h6C, r); check("R1 unmapped read", r, 32'h0);
    wr(8'h6C, 32'hFFFF_FFFF);
    rd(8'h64, r); check("R1 unmapped write port0", r, keep);

    // R6 overcurrent irrelevant without switching
    pwrCtlCap = 1'b0;
    @(negedge clk) overCurrent = 2'b11;
    @(negedge clk) overCurrent = 2'b00;
    check("R6 oc no effect", {30'b0, portPower}, 32'h3);

    // R4 flag low forces owner back
    @(negedge clk) cfgFlag = 1'b0;
    @(negedge clk);
    check("R4 flag low", {30'b0, portOwner}, 32'h3);

    finishRun();
  end
endmodule